// File: doc/BRIEF.md
# Geometry Coprocessor Data Register File

This block holds the thirty-two 32-bit data registers of a fixed-point geometry coprocessor. A host CPU reaches it through one write port and one read port. Register moves and memory loads into the coprocessor both use the same write port. The write index decides how a value is stored:

- Some registers hold 16-bit signed quantities. They keep a sign-extended copy of the low half of the written word.
- Some hold 16-bit unsigned quantities. They keep a zero-extended copy.
- The remaining ordinary registers keep the full word.

A few registers have side effects when they are written or read. The block does not carry out those effects itself:

- A write to index 15, 28 or 30 is turned away from storage. It is presented on a strobe together with its index and data, for an external handler.
- A read of index 29 raises a read strobe. The read data then comes from the handler's data input.

Ordinary reads are combinational from the stored array. A synchronous, active-high reset clears every entry.

Top module: `geo_data_regfile`

## Requirements
- R1: The first cycle after reset deasserts, every entry except index 29 reads back as 0x00000000.
- R2: A write to index 8, 9, 10 or 11 stores bits [15:0] of the write data, sign-extended from bit 15 to 32 bits.
- R3: A write to index 16, 17, 18 or 19 stores bits [15:0] of the write data with bits [31:16] forced to zero.
- R4: A write to any other index except 15, 28 and 30 stores all 32 bits unchanged. This includes index 29, although that entry cannot be read back.
- R5: While wr_en is high with index 15, 28 or 30, wr_special is high in that same cycle, and wr_special_idx and wr_special_data equal wr_idx and the unmodified wr_data. The addressed entry keeps its previous contents.
- R6: While no diverted write is presented, wr_special is low and wr_special_idx and wr_special_data are zero.
- R7: While rd_idx is 29, rd_special is high and rd_data equals rd_ext_data, whatever was last written to entry 29. For any other rd_idx, rd_special is low.
- R8: rd_data follows rd_idx combinationally. When a write and a read target the same ordinary index in one cycle, the read returns the old value, and the new value appears after the clock edge.
- R9: A clock edge with wr_en low changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all entries |
| wr_en | input | 1 | Write request |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 32 | Write word from a move or a load |
| rd_idx | input | 5 | Read register index |
| rd_ext_data | input | 32 | Data from the external handler for the read side-effect index |
| rd_data | output | 32 | Read word |
| rd_special | output | 1 | Read of the side-effect index is in progress |
| wr_special | output | 1 | Write diverted to the external handler |
| wr_special_idx | output | 5 | Index of the diverted write, zero when idle |
| wr_special_data | output | 32 | Unmodified data of the diverted write, zero when idle |

## Verification
The assertions assume that wr_en, wr_idx and wr_data are stable and known from one clock edge to the next. They also assume that rst is held for at least one edge before any property is checked, so that every entry starts at zero. The stability check on unwritten entries also relies on rd_idx changing only between edges. The bench drives every input on the falling edge. It samples outputs one time unit later for combinational results and just after the rising edge for stored results, which keeps all stimulus inside these assumptions.

// File: rtl/geo_regfile_pkg.sv
package geo_regfile_pkg;

  localparam int GR_ENTRIES = 32;
  localparam int GR_DATA_W  = 32;
  localparam int GR_HALF_W  = 16;
  localparam int GR_IDX_W   = $clog2(GR_ENTRIES);

  // How a write at a given index is stored
  typedef enum logic [1:0] {
    WK_FULL   = 2'd0,
    WK_SIGN16 = 2'd1,
    WK_ZERO16 = 2'd2,
    WK_DIVERT = 2'd3
  } wr_kind_e;

  localparam logic [GR_IDX_W-1:0] RD_DIVERT_IDX = GR_IDX_W'(29);

  function automatic wr_kind_e classify_wr(input logic [GR_IDX_W-1:0] idx);
    wr_kind_e k;
    case (idx)
      GR_IDX_W'(8), GR_IDX_W'(9), GR_IDX_W'(10), GR_IDX_W'(11):
        k = WK_SIGN16;
      GR_IDX_W'(16), GR_IDX_W'(17), GR_IDX_W'(18), GR_IDX_W'(19):
        k = WK_ZERO16;
      GR_IDX_W'(15), GR_IDX_W'(28), GR_IDX_W'(30):
        k = WK_DIVERT;
      default:
        k = WK_FULL;
    endcase
    return k;
  endfunction

  function automatic logic [GR_DATA_W-1:0] shape_word(input wr_kind_e k,
                                                      input logic [GR_DATA_W-1:0] d);
    logic [GR_DATA_W-1:0] r;
    case (k)
      WK_SIGN16: r = {{(GR_DATA_W-GR_HALF_W){d[GR_HALF_W-1]}}, d[GR_HALF_W-1:0]};
      WK_ZERO16: r = {{(GR_DATA_W-GR_HALF_W){1'b0}}, d[GR_HALF_W-1:0]};
      default:   r = d;
    endcase
    return r;
  endfunction

  function automatic logic is_rd_divert(input logic [GR_IDX_W-1:0] idx);
    return idx == RD_DIVERT_IDX;
  endfunction

endpackage

// File: rtl/geo_wr_shaper.sv
module geo_wr_shaper
  import geo_regfile_pkg::*;
#(
  parameter int DATA_W = GR_DATA_W,
  parameter int IDX_W  = GR_IDX_W
) (
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic              commit_en,
  output logic [IDX_W-1:0]  commit_idx,
  output logic [DATA_W-1:0] commit_data,
  output logic              divert_en,
  output logic [IDX_W-1:0]  divert_idx,
  output logic [DATA_W-1:0] divert_data
);

  wr_kind_e kind;

  always_comb begin
    kind        = classify_wr(wr_idx);
    commit_en   = wr_en && (kind != WK_DIVERT);
    commit_idx  = wr_idx;
    commit_data = shape_word(kind, wr_data);
    divert_en   = wr_en && (kind == WK_DIVERT);
    divert_idx  = divert_en ? wr_idx  : '0;
    divert_data = divert_en ? wr_data : '0;
  end

endmodule

// File: rtl/geo_reg_array.sv
module geo_reg_array
  import geo_regfile_pkg::*;
#(
  parameter int ENTRIES = GR_ENTRIES,
  parameter int DATA_W  = GR_DATA_W,
  parameter int HALF_W  = GR_HALF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_en,
  input  logic [IDX_W-1:0]  commit_idx,
  input  logic [DATA_W-1:0] commit_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_word
);

  logic [DATA_W-1:0] ent_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [DATA_W-1:0] word_q;
    logic              hit;
    assign hit = commit_en && (commit_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst)      word_q <= '0;
      else if (hit) word_q <= commit_data;
    end
    assign ent_q[g] = word_q;
  end

  assign rd_word = ent_q[rd_idx];

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_word == '0));

  // R2
  sign_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_en && classify_wr(commit_idx) == WK_SIGN16) |=>
      (ent_q[$past(commit_idx)][DATA_W-1:HALF_W] ==
       {(DATA_W-HALF_W){ent_q[$past(commit_idx)][HALF_W-1]}}));

  // R3
  zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_en && classify_wr(commit_idx) == WK_ZERO16) |=>
      (ent_q[$past(commit_idx)][DATA_W-1:HALF_W] == '0));

  // R5
  no_divert_store_chk: assert property (@(posedge clk) disable iff (rst)
    commit_en |-> (classify_wr(commit_idx) != WK_DIVERT));

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!commit_en && !$past(rst)) |=> (ent_q[$past(rd_idx)] == $past(rd_word)));

endmodule

// File: rtl/geo_rd_port.sv
module geo_rd_port
  import geo_regfile_pkg::*;
#(
  parameter int DATA_W = GR_DATA_W,
  parameter int IDX_W  = GR_IDX_W
) (
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] stored_word,
  input  logic [DATA_W-1:0] ext_word,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_special
);

  always_comb begin
    rd_special = is_rd_divert(rd_idx);
    rd_data    = rd_special ? ext_word : stored_word;
  end

endmodule

// File: rtl/geo_data_regfile.sv
module geo_data_regfile
  import geo_regfile_pkg::*;
#(
  parameter int ENTRIES = GR_ENTRIES,
  parameter int DATA_W  = GR_DATA_W,
  parameter int HALF_W  = GR_HALF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] rd_ext_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_special,
  output logic              wr_special,
  output logic [IDX_W-1:0]  wr_special_idx,
  output logic [DATA_W-1:0] wr_special_data
);

  logic              commit_en;
  logic [IDX_W-1:0]  commit_idx;
  logic [DATA_W-1:0] commit_data;
  logic [DATA_W-1:0] stored_word;

  geo_wr_shaper #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_shaper (
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .commit_en   (commit_en),
    .commit_idx  (commit_idx),
    .commit_data (commit_data),
    .divert_en   (wr_special),
    .divert_idx  (wr_special_idx),
    .divert_data (wr_special_data)
  );

  geo_reg_array #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .HALF_W(HALF_W)) u_array (
    .clk         (clk),
    .rst         (rst),
    .commit_en   (commit_en),
    .commit_idx  (commit_idx),
    .commit_data (commit_data),
    .rd_idx      (rd_idx),
    .rd_word     (stored_word)
  );

  geo_rd_port #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rdport (
    .rd_idx      (rd_idx),
    .stored_word (stored_word),
    .ext_word    (rd_ext_data),
    .rd_data     (rd_data),
    .rd_special  (rd_special)
  );

  // R5
  divert_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    wr_special |-> (wr_en && !commit_en && wr_special_idx == wr_idx &&
                    wr_special_data == wr_data));

  // R6
  divert_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_special |-> (wr_special_idx == '0 && wr_special_data == '0));

  // R7
  rd_special_chk: assert property (@(posedge clk) disable iff (rst)
    rd_special |-> (rd_data == rd_ext_data && rd_idx == RD_DIVERT_IDX));

  // R4
  full_store_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_en && classify_wr(commit_idx) == WK_FULL) |-> (commit_data == wr_data));

endmodule

// File: tb/test_geo_data_regfile.sv
module test_geo_data_regfile;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;
  logic [4:0]  rd_idx;
  logic [31:0] rd_ext_data;
  logic [31:0] rd_data;
  logic        rd_special;
  logic        wr_special;
  logic [4:0]  wr_special_idx;
  logic [31:0] wr_special_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  geo_data_regfile i_geo_data_regfile (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_ext_data(rd_ext_data), .rd_data(rd_data),
    .rd_special(rd_special), .wr_special(wr_special),
    .wr_special_idx(wr_special_idx), .wr_special_data(wr_special_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [4:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_idx = '0; wr_data = '0;
  endtask

  task automatic read_expect(input string req, input logic [4:0] idx, input logic [31:0] exp);
    rd_idx = idx;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic t_reset;
    rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_data = '0; rd_idx = '0; rd_ext_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 32; i++)
      if (i != 29) read_expect("R1 reset", 5'(i), 32'h0);
  endtask

  task automatic t_sign;
    do_write(5'd8,  32'h1234_8001); read_expect("R2 sign idx8",  5'd8,  32'hFFFF_8001);
    do_write(5'd9,  32'hABCD_7FFF); read_expect("R2 sign idx9",  5'd9,  32'h0000_7FFF);
    do_write(5'd11, 32'h0000_FFFF); read_expect("R2 sign idx11", 5'd11, 32'hFFFF_FFFF);
    do_write(5'd10, 32'hFFFF_0000); read_expect("R2 sign idx10", 5'd10, 32'h0000_0000);
  endtask

  task automatic t_zero;
    do_write(5'd16, 32'hDEAD_8001); read_expect("R3 zero idx16", 5'd16, 32'h0000_8001);
    do_write(5'd19, 32'h1234_FFFF); read_expect("R3 zero idx19", 5'd19, 32'h0000_FFFF);
    do_write(5'd17, 32'h8000_0000); read_expect("R3 zero idx17", 5'd17, 32'h0000_0000);
  endtask

  task automatic t_full;
    do_write(5'd0,  32'hDEAD_BEEF); read_expect("R4 full idx0",  5'd0,  32'hDEAD_BEEF);
    do_write(5'd7,  32'h8765_4321); read_expect("R4 full idx7",  5'd7,  32'h8765_4321);
    do_write(5'd12, 32'hFFFF_8000); read_expect("R4 full idx12", 5'd12, 32'hFFFF_8000);
    do_write(5'd20, 32'h0001_8000); read_expect("R4 full idx20", 5'd20, 32'h0001_8000);
    do_write(5'd31, 32'h7FFF_FFFF); read_expect("R4 full idx31", 5'd31, 32'h7FFF_FFFF);
  endtask

  task automatic t_divert;
    logic [4:0] ids [3] = '{5'd15, 5'd28, 5'd30};
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_idx = ids[k]; wr_data = 32'hA5A5_0000 | 32'(k);
      #1;
      check("R5 strobe", {31'h0, wr_special}, 32'h1);
      check("R5 idx", {27'h0, wr_special_idx}, {27'h0, ids[k]});
      check("R5 data", wr_special_data, 32'hA5A5_0000 | 32'(k));
      @(negedge clk);
      wr_en = 1'b0; wr_idx = '0; wr_data = '0;
      read_expect("R5 not stored", ids[k], 32'h0);
    end
  endtask

  task automatic t_idle_strobe;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd3; wr_data = 32'hAAAA_5555;
    #1;
    check("R6 strobe low", {31'h0, wr_special}, 32'h0);
    check("R6 idx zero", {27'h0, wr_special_idx}, 32'h0);
    check("R6 data zero", wr_special_data, 32'h0);
    @(negedge clk);
    wr_en = 1'b0; wr_idx = '0; wr_data = '0;
  endtask

  task automatic t_rd_special;
    do_write(5'd29, 32'h1111_1111);
    rd_ext_data = 32'hCAFE_F00D;
    read_expect("R7 ext data", 5'd29, 32'hCAFE_F00D);
    check("R7 strobe high", {31'h0, rd_special}, 32'h1);
    rd_ext_data = 32'h0BAD_CAFE;
    #1;
    check("R7 ext follows", rd_data, 32'h0BAD_CAFE);
    rd_idx = 5'd5;
    #1;
    check("R7 strobe low", {31'h0, rd_special}, 32'h0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd3; wr_data = 32'h1234_5678; rd_idx = 5'd3;
    #1;
    check("R8 old value", rd_data, 32'hAAAA_5555);
    @(posedge clk);
    #1;
    check("R8 new value", rd_data, 32'h1234_5678);
    @(negedge clk);
    wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    rd_idx = 5'd8;
    #1;
    check("R8 comb follow", rd_data, 32'hFFFF_8001);
  endtask

  task automatic t_wr_off;
    @(negedge clk);
    wr_en = 1'b0; wr_idx = 5'd0; wr_data = 32'h5555_AAAA;
    repeat (2) @(negedge clk);
    wr_idx = '0; wr_data = '0;
    read_expect("R9 no write", 5'd0, 32'hDEAD_BEEF);
  endtask

  initial begin
    t_reset();
    t_sign();
    t_zero();
    t_full();
    t_divert();
    t_idle_strobe();
    t_rd_special();
    t_same_cycle();
    t_wr_off();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule